// File: doc/BRIEF.md
# Shared Memory Bank Conflict Calculator

This block works out how many serialized cycles one shared-memory access takes when a primary lane group and up to `NSETS` co-issued lane sets go to the banks together. Every group supplies per-lane byte addresses, an active mask and a flag that says whether its source is a shared-memory access. Each co-issued set also has a valid bit. The block forms the union of all participating lanes and maps each address to a bank (address bits [6:2]) and a 4-byte word (address shifted right by 2). In each bank it counts how many distinct words are requested. The largest of these counts is the cycle count. Lanes that read the same word count once, so a broadcast does not conflict. There is no subwarp split: one arbiter sees every participating lane at the same time.

A one-cycle `start` pulse, accepted only while `ready` is high, captures the inputs and registers the counts. That pulse moves the controller from IDLE to CALC. In the next cycle the counters are loaded. The controller then goes from CALC to DRAIN when the loaded count is nonzero, or from CALC back to IDLE when it is zero. In DRAIN every nonzero counter decrements once per cycle. The controller goes from DRAIN to IDLE on the cycle in which the last counter reaches zero.

`unified_mode` selects between two models. In the unified model (1), only a single counter is loaded, and all the per-group counters are cleared. In the per-set model (0), each group's counter is loaded with that group's own conflict count. The block keeps a running total of bank-access cycles. It also keeps three diagnostic totals so that the unified and per-set-max models can be compared by subtraction.

Top module: `smb_conflict_calc`

## Requirements
- R1: If `op_is_mem` is 0, no lane participates. The result in `conflict_cycles` is 0, `stall` never rises, and `busy` is high for exactly one cycle (CALC).
- R2: A primary lane participates only when `prim_shared` is 1 and its bit in `prim_mask` is set. A lane of set s participates only when `set_valid[s]`, `set_shared[s]` and its bit in the mask slice `set_mask[s*NLANES +: NLANES]` are all 1.
- R3: The bank is address bits [6:2] and the word is address bits [ADDR_W-1:2]. Participating lanes that hit the same word count once. The count is the largest number of distinct words requested in any single bank.
- R4: In unified mode the count is taken over the union of the participating lanes of all groups, so different words that two groups request in one bank add together.
- R5: If the count is 0, nothing is armed: no stall occurs, the diagnostic totals do not change, and the controller goes from CALC back to IDLE.
- R6: In unified mode with count N>0, `conflict_cycles` becomes N. `busy` is high for N+1 cycles, starting in the cycle after the accepted start. `stall` is high for N-1 cycles, which are the DRAIN cycles in which the counter is still above 1 before it decrements.
- R7: `start` is accepted only while `ready` is high (IDLE). A start that is asserted while `busy` is high has no effect.
- R8: `bank_access_total` increases by the number of nonzero counters in each DRAIN cycle. This is N per unified run and the sum of the group counts per per-set run.
- R9: In per-set mode, each group counter is loaded with its own count (0 if the group does not participate). `conflict_cycles` is the largest group count M. `stall` is high for M-1 cycles and `busy` for M+1 cycles.
- R10: A unified run with N>0 adds 1 to `diag_invocations`, adds N to `diag_unified_total`, and adds the largest single-group count to `diag_perset_total`. Per-set runs leave all three unchanged.
- R11: After reset, `ready` is 1, `busy` and `stall` are 0, and every count and total is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request to evaluate the present inputs |
| unified_mode | input | 1 | 1 = unified union model, 0 = per-set maximum model |
| op_is_mem | input | 1 | Operation is a load or a store |
| prim_shared | input | 1 | Primary group targets shared memory |
| prim_mask | input | NLANES | Primary active lanes |
| prim_addr | input | NLANES*ADDR_W | Primary lane byte addresses, lane l at [l*ADDR_W +: ADDR_W] |
| set_valid | input | NSETS | Co-issued set present |
| set_shared | input | NSETS | Set source targets shared memory |
| set_mask | input | NSETS*NLANES | Set active lanes, set s at [s*NLANES +: NLANES] |
| set_addr | input | NSETS*NLANES*ADDR_W | Set lane addresses, set s lane l at [(s*NLANES+l)*ADDR_W +: ADDR_W] |
| ready | output | 1 | Controller idle, start accepted |
| busy | output | 1 | Evaluation or drain in progress |
| stall | output | 1 | Issue stage must hold |
| conflict_cycles | output | CNT_W | Count of the most recent run |
| bank_access_total | output | STAT_W | Running bank-access cycle statistic |
| diag_invocations | output | STAT_W | Unified runs armed |
| diag_unified_total | output | STAT_W | Sum of unified counts |
| diag_perset_total | output | STAT_W | Sum of per-set-max counts for unified runs |

## Verification
A wrong distinct-word flag or bank count shows up in `conflict_cycles` in the cycle right after CALC. A bad counter load or decrement changes how long `stall` and `busy` last within the same run, and it also changes the `bank_access_total` delta by the time the run ends. A wrong mode or gating decision moves the diagnostic totals at the CALC edge, so it is visible before the drain finishes. Any controller state that lingers shows up as `ready` staying low or as an extra `busy` period after an ignored start.

// File: rtl/smb_pkg.sv
package smb_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_CALC  = 2'd1,
        ST_DRAIN = 2'd2
    } smb_state_e;
endpackage

// File: rtl/smb_lane_gather.sv
// Builds the participation mask of all groups (primary first) and the
// matching flat address vector.
module smb_lane_gather #(
    parameter int NLANES = 8,
    parameter int NSETS  = 3,
    parameter int ADDR_W = 32
) (
    input  logic                           op_is_mem,
    input  logic                           prim_shared,
    input  logic [NLANES-1:0]              prim_mask,
    input  logic [NLANES*ADDR_W-1:0]       prim_addr,
    input  logic [NSETS-1:0]               set_valid,
    input  logic [NSETS-1:0]               set_shared,
    input  logic [NSETS*NLANES-1:0]        set_mask,
    input  logic [NSETS*NLANES*ADDR_W-1:0] set_addr,
    output logic [(NSETS+1)*NLANES-1:0]    all_part,
    output logic [(NSETS+1)*NLANES*ADDR_W-1:0] all_addr
);
    localparam int NGROUPS = NSETS + 1;

    assign all_addr = {set_addr, prim_addr};

    for (genvar g = 0; g < NGROUPS; g++) begin : g_grp
        if (g == 0) begin : g_prim
            assign all_part[0 +: NLANES] =
                (op_is_mem && prim_shared) ? prim_mask : '0;
        end else begin : g_set
            assign all_part[g*NLANES +: NLANES] =
                (op_is_mem && set_valid[g-1] && set_shared[g-1])
                ? set_mask[(g-1)*NLANES +: NLANES] : '0;
        end
    end
endmodule

// File: rtl/smb_distinct_max.sv
// Pairwise first-occurrence detection, then per-bank tally and maximum.
module smb_distinct_max #(
    parameter int N      = 8,
    parameter int ADDR_W = 32,
    parameter int NBANKS = 32,
    parameter int CNT_W  = 6
) (
    input  logic [N*ADDR_W-1:0] addr_flat,
    input  logic [N-1:0]        part,
    output logic [CNT_W-1:0]    max_cnt
);
    localparam int BANK_W = $clog2(NBANKS);
    localparam int WORD_W = ADDR_W - 2;

    logic [WORD_W-1:0] word_of [N];
    logic [BANK_W-1:0] bank_of [N];
    logic [N-1:0]      first;
    logic [CNT_W-1:0]  per_bank [NBANKS];

    for (genvar i = 0; i < N; i++) begin : g_lane
        assign word_of[i] = addr_flat[i*ADDR_W+2 +: WORD_W];
        assign bank_of[i] = addr_flat[i*ADDR_W+2 +: BANK_W];
    end

    // A lane is the first holder of its word when no earlier
    // participating lane asks for the same word.
    always_comb begin
        for (int i = 0; i < N; i++) begin
            first[i] = part[i];
            for (int j = 0; j < i; j++) begin
                if (part[j] && (word_of[j] == word_of[i])) first[i] = 1'b0;
            end
        end
    end

    always_comb begin
        for (int b = 0; b < NBANKS; b++) begin
            per_bank[b] = '0;
            for (int i = 0; i < N; i++) begin
                if (first[i] && (bank_of[i] == BANK_W'(b)))
                    per_bank[b] = per_bank[b] + CNT_W'(1);
            end
        end
    end

    always_comb begin
        max_cnt = '0;
        for (int b = 0; b < NBANKS; b++) begin
            if (per_bank[b] > max_cnt) max_cnt = per_bank[b];
        end
    end
endmodule

// File: rtl/smb_countdown.sv
// Loadable down-counter that stops at zero.
module smb_countdown #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             tick,
    output logic             nz,
    output logic             gt1
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                     cnt_q <= '0;
        else if (load)                  cnt_q <= load_val;
        else if (tick && cnt_q != '0)   cnt_q <= cnt_q - CNT_W'(1);
    end

    assign nz  = (cnt_q != '0);
    assign gt1 = (cnt_q > CNT_W'(1));
endmodule

// File: rtl/smb_conflict_calc.sv
module smb_conflict_calc
    import smb_pkg::*;
#(
    parameter int NLANES = 8,
    parameter int NSETS  = 3,
    parameter int ADDR_W = 32,
    parameter int NBANKS = 32,
    parameter int STAT_W = 32,
    parameter int CNT_W  = $clog2((NSETS+1)*NLANES+1)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           start,
    input  logic                           unified_mode,
    input  logic                           op_is_mem,
    input  logic                           prim_shared,
    input  logic [NLANES-1:0]              prim_mask,
    input  logic [NLANES*ADDR_W-1:0]       prim_addr,
    input  logic [NSETS-1:0]               set_valid,
    input  logic [NSETS-1:0]               set_shared,
    input  logic [NSETS*NLANES-1:0]        set_mask,
    input  logic [NSETS*NLANES*ADDR_W-1:0] set_addr,
    output logic                           ready,
    output logic                           busy,
    output logic                           stall,
    output logic [CNT_W-1:0]               conflict_cycles,
    output logic [STAT_W-1:0]              bank_access_total,
    output logic [STAT_W-1:0]              diag_invocations,
    output logic [STAT_W-1:0]              diag_unified_total,
    output logic [STAT_W-1:0]              diag_perset_total
);
    localparam int NGROUPS = NSETS + 1;
    localparam int TOTAL   = NGROUPS * NLANES;
    localparam int NCTR    = NGROUPS + 1;

    logic [TOTAL-1:0]        all_part;
    logic [TOTAL*ADDR_W-1:0] all_addr;
    logic [CNT_W-1:0]        u_max_c;
    logic [CNT_W-1:0]        g_max_c [NGROUPS];
    logic [CNT_W-1:0]        pmax_c;

    smb_state_e state_q, state_d;
    logic             accept;
    logic             mode_q;
    logic [CNT_W-1:0] u_max_q, pmax_q;
    logic [CNT_W-1:0] g_max_q [NGROUPS];
    logic [CNT_W-1:0] arm_val;
    logic [CNT_W-1:0] cnt_load [NCTR];
    logic [NCTR-1:0]  cnt_nz, cnt_gt1;
    logic [STAT_W-1:0] nz_sum;

    smb_lane_gather #(.NLANES(NLANES), .NSETS(NSETS), .ADDR_W(ADDR_W)) u_gather (
        .op_is_mem  (op_is_mem),
        .prim_shared(prim_shared),
        .prim_mask  (prim_mask),
        .prim_addr  (prim_addr),
        .set_valid  (set_valid),
        .set_shared (set_shared),
        .set_mask   (set_mask),
        .set_addr   (set_addr),
        .all_part   (all_part),
        .all_addr   (all_addr)
    );

    smb_distinct_max #(.N(TOTAL), .ADDR_W(ADDR_W), .NBANKS(NBANKS), .CNT_W(CNT_W)) u_union (
        .addr_flat(all_addr),
        .part     (all_part),
        .max_cnt  (u_max_c)
    );

    for (genvar g = 0; g < NGROUPS; g++) begin : g_grp
        smb_distinct_max #(.N(NLANES), .ADDR_W(ADDR_W), .NBANKS(NBANKS), .CNT_W(CNT_W)) u_one (
            .addr_flat(all_addr[g*NLANES*ADDR_W +: NLANES*ADDR_W]),
            .part     (all_part[g*NLANES +: NLANES]),
            .max_cnt  (g_max_c[g])
        );
    end

    always_comb begin
        pmax_c = '0;
        for (int g = 0; g < NGROUPS; g++) begin
            if (g_max_c[g] > pmax_c) pmax_c = g_max_c[g];
        end
    end

    assign accept  = start && (state_q == ST_IDLE);
    assign arm_val = mode_q ? u_max_q : pmax_q;

    // Counter 0..NGROUPS-1 belong to groups, the last one is the unified one.
    always_comb begin
        for (int g = 0; g < NGROUPS; g++) cnt_load[g] = mode_q ? '0 : g_max_q[g];
        cnt_load[NGROUPS] = mode_q ? u_max_q : '0;
    end

    for (genvar c = 0; c < NCTR; c++) begin : g_ctr
        smb_countdown #(.CNT_W(CNT_W)) u_ctr (
            .clk     (clk),
            .rst_n   (rst_n),
            .load    (state_q == ST_CALC),
            .load_val(cnt_load[c]),
            .tick    (state_q == ST_DRAIN),
            .nz      (cnt_nz[c]),
            .gt1     (cnt_gt1[c])
        );
    end

    always_comb begin
        nz_sum = '0;
        for (int c = 0; c < NCTR; c++) nz_sum = nz_sum + STAT_W'(cnt_nz[c]);
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (accept) state_d = ST_CALC;
            ST_CALC:  state_d = (arm_val != '0) ? ST_DRAIN : ST_IDLE;
            ST_DRAIN: if (cnt_gt1 == '0) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        ready = (state_q == ST_IDLE);
        busy  = (state_q != ST_IDLE);
        stall = (state_q == ST_DRAIN) && (cnt_gt1 != '0);
    end

    // Datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q             <= 1'b0;
            u_max_q            <= '0;
            pmax_q             <= '0;
            for (int g = 0; g < NGROUPS; g++) g_max_q[g] <= '0;
            conflict_cycles    <= '0;
            bank_access_total  <= '0;
            diag_invocations   <= '0;
            diag_unified_total <= '0;
            diag_perset_total  <= '0;
        end else begin
            if (accept) begin
                mode_q  <= unified_mode;
                u_max_q <= u_max_c;
                pmax_q  <= pmax_c;
                for (int g = 0; g < NGROUPS; g++) g_max_q[g] <= g_max_c[g];
            end
            if (state_q == ST_CALC) begin
                conflict_cycles <= arm_val;
                if (mode_q && (u_max_q != '0)) begin
                    diag_invocations   <= diag_invocations + STAT_W'(1);
                    diag_unified_total <= diag_unified_total + STAT_W'(u_max_q);
                    diag_perset_total  <= diag_perset_total + STAT_W'(pmax_q);
                end
            end
            if (state_q == ST_DRAIN) bank_access_total <= bank_access_total + nz_sum;
        end
    end
endmodule

// File: rtl/smb_conflict_calc_chk.sv
module smb_conflict_calc_chk #(
    parameter int NSETS  = 3,
    parameter int CNT_W  = 6,
    parameter int STAT_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              ready,
    input logic              busy,
    input logic              stall,
    input logic [CNT_W-1:0]  conflict_cycles,
    input logic [STAT_W-1:0] bank_access_total,
    input logic [STAT_W-1:0] diag_invocations,
    input logic [STAT_W-1:0] diag_unified_total,
    input logic [STAT_W-1:0] diag_perset_total
);
    localparam int NCTR = NSETS + 2;

    // R6: the stage is never held without a run in progress
    a_r6_stall_needs_busy: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> busy);

    // R7: an accepted start always opens a run
    a_r7_start_opens_run: assert property (@(posedge clk) disable iff (!rst_n)
        (start && ready) |=> busy);

    // R6: the result only moves at the end of a busy cycle
    a_r6_result_moves_in_run: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(conflict_cycles) |-> $past(busy));

    // R8: statistic is frozen while idle
    a_r8_stat_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> $stable(bank_access_total));

    // R8: statistic grows by at most one per counter per cycle
    a_r8_stat_step: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (bank_access_total - $past(bank_access_total)) <= STAT_W'(NCTR));

    // R10: invocations step by zero or one
    a_r10_inv_step: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (diag_invocations == $past(diag_invocations)) ||
                 (diag_invocations == $past(diag_invocations) + STAT_W'(1)));

    // R10: a union never has fewer conflicts than any of its parts
    a_r10_union_dominates: assert property (@(posedge clk) disable iff (!rst_n)
        diag_unified_total >= diag_perset_total);
endmodule

bind smb_conflict_calc smb_conflict_calc_chk #(
    .NSETS (NSETS),
    .CNT_W (CNT_W),
    .STAT_W(STAT_W)
) u_chk (
    .clk               (clk),
    .rst_n             (rst_n),
    .start             (start),
    .ready             (ready),
    .busy              (busy),
    .stall             (stall),
    .conflict_cycles   (conflict_cycles),
    .bank_access_total (bank_access_total),
    .diag_invocations  (diag_invocations),
    .diag_unified_total(diag_unified_total),
    .diag_perset_total (diag_perset_total)
);

// File: tb/smb_conflict_calc_tb.sv
module smb_conflict_calc_tb;
    localparam int NL = 8;
    localparam int NS = 3;
    localparam int NG = NS + 1;
    localparam int AW = 32;
    localparam int CW = $clog2(NG*NL+1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic unified_mode = 1'b1;
    logic op_is_mem = 1'b0;
    logic prim_shared = 1'b0;
    logic [NL-1:0] prim_mask = '0;
    logic [NL*AW-1:0] prim_addr = '0;
    logic [NS-1:0] set_valid = '0, set_shared = '0;
    logic [NS*NL-1:0] set_mask = '0;
    logic [NS*NL*AW-1:0] set_addr = '0;
    logic ready, busy, stall;
    logic [CW-1:0] conflict_cycles;
    logic [31:0] bank_access_total, diag_invocations, diag_unified_total, diag_perset_total;

    always #10 clk = ~clk;

    smb_conflict_calc u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .unified_mode(unified_mode),
        .op_is_mem(op_is_mem), .prim_shared(prim_shared), .prim_mask(prim_mask),
        .prim_addr(prim_addr), .set_valid(set_valid), .set_shared(set_shared),
        .set_mask(set_mask), .set_addr(set_addr), .ready(ready), .busy(busy),
        .stall(stall), .conflict_cycles(conflict_cycles),
        .bank_access_total(bank_access_total), .diag_invocations(diag_invocations),
        .diag_unified_total(diag_unified_total), .diag_perset_total(diag_perset_total)
    );

    // stimulus image, group 0 = primary
    logic [31:0] ad [NG][NL];
    logic [NL-1:0] mk [NG];
    logic vld [NG];
    logic shr [NG];
    logic opm, um;

    int n_checks = 0, n_fail = 0, n_push = 0, n_pop = 0;

    typedef struct {
        string tag;
        bit    uni;
        int    cyc, stl, bsy, stat, inv, ut, pt;
    } exp_t;
    exp_t sb [$];

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    function automatic bit takes(input int g, input int l);
        return opm && shr[g] && (g == 0 || vld[g]) && mk[g][l];
    endfunction

    // reference: gather unique words per bank in lists
    function automatic int conf(input logic [NG-1:0] gsel);
        logic [29:0] seen [32][NG*NL];
        int ns [32];
        int best = 0;
        for (int b = 0; b < 32; b++) ns[b] = 0;
        for (int g = 0; g < NG; g++) begin
            if (!gsel[g]) continue;
            for (int l = 0; l < NL; l++) begin
                int b;
                bit found;
                if (!takes(g, l)) continue;
                b = int'(ad[g][l][6:2]);
                found = 1'b0;
                for (int k = 0; k < ns[b]; k++) if (seen[b][k] == ad[g][l][31:2]) found = 1'b1;
                if (!found) begin
                    seen[b][ns[b]] = ad[g][l][31:2];
                    ns[b]++;
                end
            end
        end
        for (int b = 0; b < 32; b++) if (ns[b] > best) best = ns[b];
        return best;
    endfunction

    task automatic apply();
        unified_mode = um;
        op_is_mem    = opm;
        prim_shared  = shr[0];
        prim_mask    = mk[0];
        for (int l = 0; l < NL; l++) prim_addr[l*AW +: AW] = ad[0][l];
        for (int s = 0; s < NS; s++) begin
            set_valid[s]  = vld[s+1];
            set_shared[s] = shr[s+1];
            set_mask[s*NL +: NL] = mk[s+1];
            for (int l = 0; l < NL; l++) set_addr[(s*NL+l)*AW +: AW] = ad[s+1][l];
        end
    endtask

    task automatic clear_img();
        for (int g = 0; g < NG; g++) begin
            mk[g] = '0; vld[g] = 1'b0; shr[g] = 1'b0;
            for (int l = 0; l < NL; l++) ad[g][l] = '0;
        end
        opm = 1'b1; um = 1'b1;
    endtask

    // driver: compute expectation, push, stimulate
    task automatic run(input string tag, input bit ign);
        exp_t e;
        int u, pm, sm, gc, n;
        u = conf('1);
        pm = 0; sm = 0;
        for (int g = 0; g < NG; g++) begin
            gc = conf(NG'(1) << g);
            sm += gc;
            if (gc > pm) pm = gc;
        end
        n = um ? u : pm;
        e.tag = tag; e.uni = um; e.cyc = n;
        e.bsy = n + 1; e.stl = (n > 0) ? n - 1 : 0;
        e.stat = um ? n : sm;
        e.inv = (um && n > 0) ? 1 : 0;
        e.ut  = (um && n > 0) ? n : 0;
        e.pt  = (um && n > 0) ? pm : 0;
        sb.push_back(e);
        n_push++;
        @(negedge clk);
        while (!ready) @(negedge clk);
        apply();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (ign) begin
            // change the stimulus and pulse start during the run
            for (int l = 0; l < NL; l++) ad[0][l] = 32'(l) * 32'd128 + 32'h4000;
            mk[0] = '1; shr[0] = 1'b1; um = ~um;
            apply();
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (busy) @(negedge clk);
        @(negedge clk);
        @(negedge clk);
    endtask

    // monitor: measure each run and compare with the scoreboard head
    logic pbusy = 1'b0;
    int   bcnt, scnt;
    longint b_stat, b_inv, b_ut, b_pt;
    always @(negedge clk) begin
        if (rst_n) begin
            if (busy && !pbusy) begin
                bcnt = 0; scnt = 0;
                b_stat = bank_access_total; b_inv = diag_invocations;
                b_ut = diag_unified_total; b_pt = diag_perset_total;
            end
            if (busy) bcnt++;
            if (stall) scnt++;
            if (!busy && pbusy) begin
                n_pop++;
                if (sb.size() == 0) begin
                    check(1'b0, "R7", "unexpected run", n_pop, n_push);
                end else begin
                    exp_t e;
                    string tr;
                    e = sb.pop_front();
                    tr = e.uni ? "R6" : "R9";
                    check(conflict_cycles == CW'(e.cyc), e.tag, "conflict_cycles", conflict_cycles, e.cyc);
                    check(bcnt == e.bsy, tr, "busy cycles", bcnt, e.bsy);
                    check(scnt == e.stl, tr, "stall cycles", scnt, e.stl);
                    check(longint'(bank_access_total) - b_stat == e.stat, "R8", "bank access delta",
                          longint'(bank_access_total) - b_stat, e.stat);
                    check(longint'(diag_invocations) - b_inv == e.inv, "R10", "invocations delta",
                          longint'(diag_invocations) - b_inv, e.inv);
                    check(longint'(diag_unified_total) - b_ut == e.ut, "R10", "unified delta",
                          longint'(diag_unified_total) - b_ut, e.ut);
                    check(longint'(diag_perset_total) - b_pt == e.pt, "R10", "perset delta",
                          longint'(diag_perset_total) - b_pt, e.pt);
                end
            end
            pbusy = busy;
        end
    end

    initial begin
        #(20ns * 100000);
        check(1'b0, "R6", "watchdog expired", 0, 1);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        clear_img();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        check(ready == 1'b1, "R11", "ready", ready, 1);
        check(busy == 1'b0 && stall == 1'b0, "R11", "busy|stall", {busy, stall}, 0);
        check(conflict_cycles == '0, "R11", "conflict_cycles", conflict_cycles, 0);
        check(bank_access_total == 0 && diag_invocations == 0 &&
              diag_unified_total == 0 && diag_perset_total == 0, "R11", "totals", bank_access_total, 0);

        // R3 broadcast: all lanes one word
        clear_img(); shr[0] = 1; mk[0] = '1;
        for (int l = 0; l < NL; l++) ad[0][l] = 32'h100;
        run("R3", 0);
        // R3 unit stride: distinct banks
        for (int l = 0; l < NL; l++) ad[0][l] = 32'(l) * 4;
        run("R3", 0);
        // R3 same bank, distinct words
        for (int l = 0; l < NL; l++) ad[0][l] = 32'(l) * 128;
        run("R3", 0);
        // R3 mixed: two-way duplicates in bank 3
        for (int l = 0; l < NL; l++) ad[0][l] = 32'h0C + 32'(l/2) * 128;
        run("R3", 0);

        // R4 union across groups, with a duplicate set
        clear_img(); shr[0] = 1; mk[0] = 8'h0F;
        for (int l = 0; l < NL; l++) ad[0][l] = 32'(l) * 128;
        vld[1] = 1; shr[1] = 1; mk[1] = '1;
        for (int l = 0; l < NL; l++) ad[1][l] = 32'h1000 + 32'(l) * 128;
        vld[2] = 1; shr[2] = 1; mk[2] = 8'h0F;
        for (int l = 0; l < NL; l++) ad[2][l] = 32'(l) * 128;
        run("R4", 0);
        // R9 same stimulus, per-set model
        um = 0;
        run("R9", 0);

        // R2 exclusion of invalid, non-shared and masked-off lanes
        clear_img(); shr[0] = 1; mk[0] = 8'h01;
        for (int g = 1; g < NG; g++)
            for (int l = 0; l < NL; l++) ad[g][l] = 32'(l) * 128 + 32'(g) * 32'h2000;
        vld[1] = 0; shr[1] = 1; mk[1] = '1;
        vld[2] = 1; shr[2] = 0; mk[2] = '1;
        vld[3] = 1; shr[3] = 1; mk[3] = 8'h00;
        run("R2", 0);
        // R2 primary excluded when not shared, set lanes kept
        shr[0] = 0; mk[0] = '1; mk[3] = 8'h03;
        run("R2", 0);

        // R1 not a memory operation
        clear_img(); opm = 0; shr[0] = 1; mk[0] = '1;
        for (int l = 0; l < NL; l++) ad[0][l] = 32'(l) * 128;
        run("R1", 0);
        // R5 no participating lane
        clear_img(); mk[0] = '1;
        run("R5", 0);
        // R5 per-set model, nothing participating
        um = 0;
        run("R5", 0);

        // R7 start during a run is ignored
        clear_img(); shr[0] = 1; mk[0] = '1;
        for (int l = 0; l < NL; l++) ad[0][l] = 32'(l) * 128;
        run("R7", 1);

        repeat (5) @(negedge clk);
        check(sb.size() == 0, "R7", "scoreboard left", sb.size(), 0);
        check(n_pop == n_push, "R7", "runs seen", n_pop, n_push);
        check(busy == 1'b0, "R7", "busy after ignored start", busy, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule